// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

This block collects interrupt events from a set of general-purpose input lines. The lines are arranged in groups of sixteen. Each line has a programmable trigger condition, a mask bit and a sticky pending bit. Software programs the triggers and masks through a small word-addressed register port. It then reads one service register, which names the single unmasked pending line to handle next.

The service register is eight bits wide. The upper nibble holds a one-based group number and the lower nibble holds the line inside that group. A group number of zero means that nothing needs service. An interrupt handler loops: it reads the service register, handles the named line, clears that line's pending bit with a write-one-to-clear, and reads again until the group is zero. One combined interrupt output is raised while any line awaits service.

A two-state machine, `SVC_IDLE` and `SVC_ACTIVE`, owns the service register and the interrupt output. The transition IDLE→ACTIVE is taken when the priority search finds an unmasked pending line. ACTIVE→ACTIVE is taken while such a line remains, and the service register is reloaded with the current winner on every cycle. ACTIVE→IDLE is taken when no unmasked pending line is left, and the register returns to zero. IDLE→IDLE is taken otherwise.

Top module: `gsvc_encoder`

## Requirements
- R1: Reading address 0x284 returns the service word: the group number (storage group index plus one) in bits [7:4] and the line within the group in bits [3:0]. All bits above 7 read as zero.
- R2: When no line is both pending and unmasked, the service word reads 0x00 (group zero).
- R3: Storage groups 2k and 2k+1 share 32-bit word k. The lower group is in bits [15:0] and the upper group in bits [31:16], so global line n sits at bit n mod 32 of word n/32. Trigger words are at 0x200+4k, mask words at 0x240+4k and pending words at 0x260+4k, and all of them read back at those addresses.
- R4: Each 4-bit trigger selector serves four consecutive lines and sits at bits 4*(b/4) of the word, where b is the line's bit in that word. The codes are: 0 = level low, 1 = level high, 2 = falling edge, 4 = rising edge, 6 = either edge. Any other code detects nothing.
- R5: A mask bit of 1 keeps its line out of the service word and off the interrupt output, but the pending bit of a masked line still records events.
- R6: When several lines are eligible, the lowest group wins, and within that group the lowest line wins.
- R7: `irq_out` is high exactly when the service word's group field is nonzero.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An event detected in the same cycle as the clear keeps the bit set, so a level trigger whose level persists cannot be cleared.
- R9: The cycle after a pending bit is cleared, the service word names the next eligible line, or reads zero if none is left.
- R10: Reading address 0x288 returns the service-valid flag in bit 0, equal to `irq_out`, with all other bits zero.
- R11: After reset every mask bit is 1, every pending bit is 0, every trigger selector holds code 0xF (no detection), the service word is 0 and `irq_out` is low.
- R12: Writes to 0x284 and 0x288 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gpio_in | input | 16*NUM_GROUPS | Raw input lines, global line n = group*16 + line |
| bus_addr | input | ADDR_W | Register byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational, no side effects) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the following. The interrupt output agrees with the service group. Any reported line was pending and unmasked in the cycle before. No lower-numbered eligible line was passed over. The service word is zero whenever nothing was eligible. Reads of the service and service-valid addresses carry the right value with zero upper bits.

The trigger code decoding, the sharing of one selector by four lines, and the word and bit placement of each line can only be shown by the directed scenarios. The same holds for masking while the pending bit still records, the rule that a set outweighs a clear, and the service register walking through several pending lines as each one is acknowledged.

// File: rtl/gsvc_pkg.sv
package gsvc_pkg;

    localparam int LINES_PER_GROUP = 16;
    localparam int WORD_W          = 32;
    localparam int SEL_W           = 4;
    localparam logic [SEL_W-1:0] SEL_OFF = 4'hF;

    typedef enum logic {
        SVC_IDLE,
        SVC_ACTIVE
    } svc_state_e;

    typedef struct packed {
        logic [3:0] grp;
        logic [3:0] line;
    } svc_word_t;

    // Decide whether a line raises an event this cycle for a given code.
    function automatic logic trig_hit(input logic [SEL_W-1:0] code,
                                      input logic cur,
                                      input logic prev);
        logic hit;
        case (code)
            4'd0:    hit = ~cur;
            4'd1:    hit = cur;
            4'd2:    hit = prev & ~cur;
            4'd4:    hit = ~prev & cur;
            4'd6:    hit = prev ^ cur;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gsvc_sync.sv
module gsvc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];

endmodule

// File: rtl/gsvc_detect.sv
module gsvc_detect
    import gsvc_pkg::*;
#(
    parameter int NL   = 64,
    parameter int PADW = 64
) (
    input  logic [NL-1:0]   cur,
    input  logic [NL-1:0]   prev,
    input  logic [PADW-1:0] ctrl,
    output logic [NL-1:0]   hit
);

    // Word boundaries are multiples of four lines, so the selector of
    // global line n sits at bits 4*(n/4) of the flat trigger vector.
    for (genvar n = 0; n < NL; n++) begin : g_line
        localparam int SEL_LSB = SEL_W * (n / 4);
        assign hit[n] = trig_hit(ctrl[SEL_LSB +: SEL_W], cur[n], prev[n]);
    end

endmodule

// File: rtl/gsvc_regfile.sv
module gsvc_regfile
    import gsvc_pkg::*;
#(
    parameter int NL        = 64,
    parameter int NW        = 2,
    parameter int PADW      = 64,
    parameter int AW        = 12,
    parameter int CTRL_BASE = 'h200,
    parameter int MASK_BASE = 'h240,
    parameter int PEND_BASE = 'h260,
    parameter int SVC_ADDR  = 'h284,
    parameter int SVCP_ADDR = 'h288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NL-1:0]     hit,
    input  svc_word_t         svc,
    input  logic              svc_valid,
    output logic [PADW-1:0]   ctrl_q,
    output logic [NL-1:0]     mask_q,
    output logic [NL-1:0]     pend_q,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [PADW-1:0] VALID = {PADW{1'b1}} >> (PADW - NL);

    logic [PADW-1:0] mask_r;
    logic [PADW-1:0] pend_r;
    logic [PADW-1:0] pend_clr;
    logic [PADW-1:0] pend_d;
    logic [NW-1:0]   wr_ctrl;
    logic [NW-1:0]   wr_mask;
    logic [NW-1:0]   wr_pend;

    for (genvar w = 0; w < NW; w++) begin : g_dec
        assign wr_ctrl[w] = wr && (addr == AW'(CTRL_BASE + 4 * w));
        assign wr_mask[w] = wr && (addr == AW'(MASK_BASE + 4 * w));
        assign wr_pend[w] = wr && (addr == AW'(PEND_BASE + 4 * w));
    end

    always_comb begin
        pend_clr = '0;
        for (int w = 0; w < NW; w++) begin
            if (wr_pend[w]) begin
                pend_clr[w*WORD_W +: WORD_W] = wdata;
            end
        end
        // New events outrank a clear arriving in the same cycle.
        pend_d = ((pend_r & ~pend_clr) | PADW'(hit)) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= {(PADW/SEL_W){SEL_OFF}};
            mask_r <= VALID;
            pend_r <= '0;
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (wr_ctrl[w]) begin
                    ctrl_q[w*WORD_W +: WORD_W] <= wdata;
                end
                if (wr_mask[w]) begin
                    mask_r[w*WORD_W +: WORD_W] <= wdata & VALID[w*WORD_W +: WORD_W];
                end
            end
            pend_r <= pend_d;
        end
    end

    assign mask_q = mask_r[NL-1:0];
    assign pend_q = pend_r[NL-1:0];

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (addr == AW'(CTRL_BASE + 4 * w)) rdata = ctrl_q[w*WORD_W +: WORD_W];
            if (addr == AW'(MASK_BASE + 4 * w)) rdata = mask_r[w*WORD_W +: WORD_W];
            if (addr == AW'(PEND_BASE + 4 * w)) rdata = pend_r[w*WORD_W +: WORD_W];
        end
        if (addr == AW'(SVC_ADDR))  rdata = {24'd0, svc};
        if (addr == AW'(SVCP_ADDR)) rdata = {31'd0, svc_valid};
    end

endmodule

// File: rtl/gsvc_prio.sv
module gsvc_prio
    import gsvc_pkg::*;
#(
    parameter int NL = 64
) (
    input  logic [NL-1:0] act,
    output logic          found,
    output svc_word_t     win
);

    int idx;

    // Scan from the top down so that the lowest index is the last to land.
    always_comb begin
        found = 1'b0;
        idx   = 0;
        for (int n = NL - 1; n >= 0; n--) begin
            if (act[n]) begin
                found = 1'b1;
                idx   = n;
            end
        end
        win.grp  = 4'(idx / LINES_PER_GROUP + 1);
        win.line = 4'(idx % LINES_PER_GROUP);
    end

endmodule

// File: rtl/gsvc_encoder.sv
module gsvc_encoder
    import gsvc_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 12,
    parameter int CTRL_BASE   = 'h200,
    parameter int MASK_BASE   = 'h240,
    parameter int PEND_BASE   = 'h260,
    parameter int SVC_ADDR    = 'h284,
    parameter int SVCP_ADDR   = 'h288
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] gpio_in,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic                                 bus_wr,
    input  logic [WORD_W-1:0]                    bus_wdata,
    output logic [WORD_W-1:0]                    bus_rdata,
    output logic                                 irq_out
);

    localparam int NL   = NUM_GROUPS * LINES_PER_GROUP;
    localparam int NW   = (NUM_GROUPS + 1) / 2;
    localparam int PADW = NW * WORD_W;

    logic [NL-1:0]   cur;
    logic [NL-1:0]   prev;
    logic [NL-1:0]   hit;
    logic [PADW-1:0] ctrl_q;
    logic [NL-1:0]   mask_q;
    logic [NL-1:0]   pend_q;
    logic [NL-1:0]   act;
    logic            found;
    svc_word_t       win;
    svc_word_t       svc_q;
    svc_state_e      state;
    svc_state_e      state_nxt;

    gsvc_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_in),
        .cur  (cur),
        .prev (prev)
    );

    gsvc_detect #(.NL(NL), .PADW(PADW)) u_detect (
        .cur (cur),
        .prev(prev),
        .ctrl(ctrl_q),
        .hit (hit)
    );

    gsvc_regfile #(
        .NL(NL), .NW(NW), .PADW(PADW), .AW(ADDR_W),
        .CTRL_BASE(CTRL_BASE), .MASK_BASE(MASK_BASE), .PEND_BASE(PEND_BASE),
        .SVC_ADDR(SVC_ADDR), .SVCP_ADDR(SVCP_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .hit      (hit),
        .svc      (svc_q),
        .svc_valid(irq_out),
        .ctrl_q   (ctrl_q),
        .mask_q   (mask_q),
        .pend_q   (pend_q),
        .rdata    (bus_rdata)
    );

    assign act = pend_q & ~mask_q;

    gsvc_prio #(.NL(NL)) u_prio (
        .act  (act),
        .found(found),
        .win  (win)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SVC_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SVC_IDLE:   state_nxt = found ? SVC_ACTIVE : SVC_IDLE;
            SVC_ACTIVE: state_nxt = found ? SVC_ACTIVE : SVC_IDLE;
        endcase
    end

    // Outputs: service word reloaded every cycle from the current winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else begin
            unique case (state_nxt)
                SVC_ACTIVE: svc_q <= win;
                SVC_IDLE:   svc_q <= '0;
            endcase
        end
    end

    assign irq_out = (state == SVC_ACTIVE);

endmodule

// File: rtl/gsvc_encoder_chk.sv
module gsvc_encoder_chk #(
    parameter int NL        = 64,
    parameter int AW        = 12,
    parameter int SVC_ADDR  = 'h284,
    parameter int SVCP_ADDR = 'h288
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_out,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_rdata,
    input logic [7:0]    svc_q,
    input logic [NL-1:0] pend_q,
    input logic [NL-1:0] mask_q
);

    logic [NL-1:0] past_act;
    logic          rep_ok;
    logic          lower_busy;
    int            idx_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_act <= '0;
        else        past_act <= pend_q & ~mask_q;
    end

    always_comb begin
        idx_c      = (svc_q[7:4] == 4'd0) ? 0 : (int'(svc_q[7:4]) - 1) * 16 + int'(svc_q[3:0]);
        rep_ok     = (idx_c < NL) ? past_act[idx_c] : 1'b0;
        lower_busy = 1'b0;
        for (int n = 0; n < NL; n++) begin
            if (n < idx_c && past_act[n]) lower_busy = 1'b1;
        end
    end

    // R7
    a_r7_irq_tracks_group: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (svc_q[7:4] != 4'd0));

    // R5: a reported line was eligible one cycle earlier
    a_r5_reported_line_active: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q[7:4] != 4'd0) |-> rep_ok);

    // R6
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q[7:4] != 4'd0) |-> !lower_busy);

    // R2
    a_r2_idle_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (past_act == '0) |-> (svc_q == 8'd0));

    // R1
    a_r1_service_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(SVC_ADDR)) |-> (bus_rdata == {24'd0, svc_q}));

    // R10
    a_r10_valid_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(SVCP_ADDR)) |-> (bus_rdata == {31'd0, irq_out}));

endmodule

bind gsvc_encoder gsvc_encoder_chk #(
    .NL(NL), .AW(ADDR_W), .SVC_ADDR(SVC_ADDR), .SVCP_ADDR(SVCP_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .svc_q    (svc_q),
    .pend_q   (pend_q),
    .mask_q   (mask_q)
);

// File: tb/gsvc_encoder_test.sv
module gsvc_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] gpio_in = '1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gsvc_encoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio_in  (gpio_in),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input string what,
                            input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, what, d, exp);
    endtask

    task automatic t_reset;
        rd_check("R11", "mask word 0", 12'h240, 32'hFFFF_FFFF);
        rd_check("R11", "mask word 1", 12'h244, 32'hFFFF_FFFF);
        rd_check("R11", "pending word 0", 12'h260, 32'h0);
        rd_check("R11", "trigger word 1", 12'h204, 32'hFFFF_FFFF);
        rd_check("R11", "service word", 12'h284, 32'h0);
        check("R11", "irq after reset", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_rising_single;
        wr(12'h200, 32'h4444_4444);
        wr(12'h204, 32'h4444_4444);
        wr(12'h260, 32'hFFFF_FFFF);
        wr(12'h264, 32'hFFFF_FFFF);
        wr(12'h240, 32'hFFFF_FFDF);
        @(negedge clk) gpio_in[5] = 1'b0;
        wait_cyc(6);
        rd_check("R4", "falling edge ignored by rising code", 12'h260, 32'h0);
        @(negedge clk) gpio_in[5] = 1'b1;
        wait_cyc(6);
        rd_check("R1", "service word line 5", 12'h284, 32'h15);
        check("R7", "irq raised", {31'd0, irq_out}, 32'h1);
        rd_check("R10", "service valid", 12'h288, 32'h1);
        wr(12'h260, 32'h0000_0020);
        wait_cyc(2);
        rd_check("R9", "service after ack", 12'h284, 32'h0);
        check("R7", "irq dropped", {31'd0, irq_out}, 32'h0);
        rd_check("R10", "service valid clear", 12'h288, 32'h0);
    endtask

    task automatic t_priority_walk;
        logic [31:0] exp_seq [6];
        logic [11:0] ack_addr [5];
        logic [31:0] ack_bit [5];
        exp_seq = '{32'h19, 32'h24, 32'h2C, 32'h33, 32'h42, 32'h00};
        ack_addr = '{12'h260, 12'h260, 12'h260, 12'h264, 12'h264};
        ack_bit  = '{32'h0000_0200, 32'h0010_0000, 32'h1000_0000,
                     32'h0000_0008, 32'h0004_0000};
        wr(12'h240, 32'h0);
        wr(12'h244, 32'h0);
        @(negedge clk);
        gpio_in[9] = 1'b0; gpio_in[20] = 1'b0; gpio_in[28] = 1'b0;
        gpio_in[35] = 1'b0; gpio_in[50] = 1'b0;
        wait_cyc(6);
        @(negedge clk);
        gpio_in[9] = 1'b1; gpio_in[20] = 1'b1; gpio_in[28] = 1'b1;
        gpio_in[35] = 1'b1; gpio_in[50] = 1'b1;
        wait_cyc(6);
        rd_check("R3", "pending word 0 placement", 12'h260, 32'h1010_0200);
        rd_check("R3", "pending word 1 placement", 12'h264, 32'h0004_0008);
        for (int i = 0; i < 5; i++) begin
            rd_check("R6", "priority order", 12'h284, exp_seq[i]);
            wr(ack_addr[i], ack_bit[i]);
            wait_cyc(2);
        end
        rd_check("R9", "walk ends at group zero", 12'h284, exp_seq[5]);
    endtask

    task automatic t_mask_and_w1c;
        wr(12'h244, 32'hFFFF_FFFF);
        @(negedge clk) gpio_in[40] = 1'b0;
        wait_cyc(6);
        @(negedge clk) gpio_in[40] = 1'b1;
        wait_cyc(6);
        rd_check("R5", "masked line not serviced", 12'h284, 32'h0);
        check("R5", "masked line no irq", {31'd0, irq_out}, 32'h0);
        rd_check("R5", "masked line still pending", 12'h264, 32'h0000_0100);
        wr(12'h244, 32'h0);
        wait_cyc(2);
        rd_check("R5", "unmasked line serviced", 12'h284, 32'h38);
        wr(12'h264, 32'h0);
        wait_cyc(2);
        rd_check("R8", "zero write keeps pending", 12'h264, 32'h0000_0100);
        rd_check("R8", "zero write keeps service", 12'h284, 32'h38);
        wr(12'h264, 32'h0000_0100);
        wait_cyc(2);
        rd_check("R8", "one write clears pending", 12'h264, 32'h0);
    endtask

    task automatic t_level_high;
        wr(12'h204, 32'h1444_4444);
        wait_cyc(3);
        rd_check("R3", "trigger word 1 readback", 12'h204, 32'h1444_4444);
        rd_check("R4", "level high shared selector", 12'h264, 32'hF000_0000);
        rd_check("R6", "lowest line of four", 12'h284, 32'h4C);
        wr(12'h264, 32'h1000_0000);
        wait_cyc(2);
        rd_check("R8", "set wins over clear", 12'h264, 32'hF000_0000);
        @(negedge clk) gpio_in[63:60] = 4'h0;
        wait_cyc(6);
        wr(12'h264, 32'hF000_0000);
        wait_cyc(2);
        rd_check("R8", "clear after level gone", 12'h264, 32'h0);
        rd_check("R2", "nothing eligible", 12'h284, 32'h0);
        wr(12'h204, 32'hFFFF_FFFF);
    endtask

    task automatic t_codes;
        wr(12'h240, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_3026);
        wr(12'h260, 32'hFFFF_FFFF);
        wait_cyc(2);
        @(negedge clk);
        gpio_in[1] = 1'b0; gpio_in[5] = 1'b0; gpio_in[8] = 1'b0; gpio_in[12] = 1'b0;
        wait_cyc(6);
        rd_check("R4", "both, falling, level low; code 3 silent", 12'h260, 32'h0000_0122);
        rd_check("R5", "masked lines not serviced", 12'h284, 32'h0);
        wr(12'h260, 32'h0000_0122);
        wait_cyc(2);
        rd_check("R4", "level low persists", 12'h260, 32'h0000_0100);
        @(negedge clk);
        gpio_in[1] = 1'b1; gpio_in[5] = 1'b1; gpio_in[8] = 1'b1; gpio_in[12] = 1'b1;
        wait_cyc(6);
        rd_check("R4", "rise seen by both-edge only", 12'h260, 32'h0000_0102);
    endtask

    task automatic t_read_only;
        wr(12'h284, 32'hFFFF_FFFF);
        wr(12'h288, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd_check("R12", "service word unchanged", 12'h284, 32'h0);
        rd_check("R12", "service valid unchanged", 12'h288, 32'h0);
        rd_check("R12", "mask word untouched", 12'h240, 32'hFFFF_FFFF);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_rising_single();
        t_priority_walk();
        t_mask_and_w1c();
        t_level_high();
        t_codes();
        t_read_only();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule